// File: doc/BRIEF.md
# Reconfigurable Johnson Counter

This block is a chain of `STAGES` flip-flops whose input feedback can be changed while it runs. The same chain works in three ways. As a twisted-ring counter, it produces a sequence of vectors in which only one bit changes per step. As a rotator, it cycles the vector it holds through all of its rotated forms. As a clearing chain, it fills every stage with zeros.

A pattern generator uses the counting form to step to a new single-input-change vector. It then switches to the rotating form to shift that vector's rotations out into scan chains one clock at a time. The clearing form brings the chain to a known starting point.

The parallel state and a serial tap of the last stage are the outputs. An enable input gates every update. A synchronous reset zeroes the chain.

Top module: `johnson_reconfig`

## Requirements
- R1: With `rotate_mode`=0, stage 0 loads the inverse of the last stage. Starting from all zeros, after k enabled clocks (1 ≤ k ≤ STAGES) stages 0..k-1 are 1 and the others are 0. After STAGES+k clocks, stages 0..k-1 are 0 and the others are 1. The state returns to all zeros after 2·STAGES clocks.
- R2: Each enabled clock with `rotate_mode`=0 changes exactly one bit of `state`.
- R3: With `rotate_mode`=1 and `keep_fill`=1, one enabled clock moves stage STAGES-1 into stage 0 and each stage i-1 into stage i, so bit i of `state` is stage i.
- R4: After exactly STAGES consecutive rotation clocks, `state` equals the value it held before the rotation began, for every vector reachable by counting.
- R5: With `rotate_mode`=1 and `keep_fill`=0, stage 0 loads 0 and the other stages shift up by one. After STAGES such clocks, every stage is 0.
- R6: While `enable`=0, `state` holds in every mode.
- R7: `rst`=1 at a rising clock edge clears every stage to 0, whatever the values of `enable` and the mode inputs.
- R8: `serial_out` always equals bit STAGES-1 of `state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Update enable |
| rotate_mode | input | 1 | 0: twisted-ring count, 1: shift-register forms |
| keep_fill | input | 1 | With rotate_mode=1: 1 rotates, 0 shifts in zeros |
| state | output | STAGES | Parallel stage values, bit i is stage i |
| serial_out | output | 1 | Last stage |

## Verification
The assertions assume that the mode inputs are stable across each enabled edge and never X once reset has been released. The bench drives all inputs one time unit after the rising edge, so every edge sees settled values. The single-bit-change and ones-count properties rely on this. The bench never leaves the state set by reset except through the three feedback forms, and it sweeps every counting state through a full rotation.

// File: rtl/johnson_reconfig_pkg.sv
package johnson_reconfig_pkg;

   typedef enum logic [1:0] {
      FB_INVERT = 2'd0,
      FB_PASS   = 2'd1,
      FB_ZERO   = 2'd2
   } fb_kind_e;

   function automatic fb_kind_e pick_feedback(input logic rotate_mode, input logic keep_fill);
      if (!rotate_mode)   return FB_INVERT;
      else if (keep_fill) return FB_PASS;
      else                return FB_ZERO;
   endfunction

endpackage

// File: rtl/johnson_reconfig_feedback.sv
module johnson_reconfig_feedback
   import johnson_reconfig_pkg::*;
(
   input  fb_kind_e kind,
   input  logic     tail_bit,
   output logic     head_bit
);

   always_comb begin
      unique case (kind)
         FB_INVERT: head_bit = ~tail_bit;
         FB_PASS:   head_bit = tail_bit;
         default:   head_bit = 1'b0;
      endcase
   end

endmodule

// File: rtl/johnson_reconfig_chain.sv
module johnson_reconfig_chain #(
   parameter int STAGES = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enable,
   input  logic              head_bit,
   output logic [STAGES-1:0] q
);

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic d;
      if (i == 0) begin : g_head
         assign d = head_bit;
      end else begin : g_body
         assign d = q[i-1];
      end
      always_ff @(posedge clk) begin
         if (rst)         q[i] <= 1'b0;
         else if (enable) q[i] <= d;
      end
   end

   // R6: state holds while the enable is low
   a_r6_hold: assert property (@(posedge clk) disable iff (rst)
      !enable |=> $stable(q));

   // R7: reset clears every stage
   a_r7_reset_clear: assert property (@(posedge clk)
      rst |=> (q == '0));

endmodule

// File: rtl/johnson_reconfig.sv
module johnson_reconfig
   import johnson_reconfig_pkg::*;
#(
   parameter int STAGES = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enable,
   input  logic              rotate_mode,
   input  logic              keep_fill,
   output logic [STAGES-1:0] state,
   output logic              serial_out
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("johnson_reconfig: STAGES must be at least 2");
   end

   fb_kind_e kind;
   logic     head_bit;

   assign kind = pick_feedback(rotate_mode, keep_fill);

   johnson_reconfig_feedback u_fb (
      .kind     (kind),
      .tail_bit (state[LAST]),
      .head_bit (head_bit)
   );

   johnson_reconfig_chain #(.STAGES(STAGES)) u_chain (
      .clk      (clk),
      .rst      (rst),
      .enable   (enable),
      .head_bit (head_bit),
      .q        (state)
   );

   assign serial_out = state[LAST];

   // R2: counting changes exactly one bit per step
   a_r2_single_change: assert property (@(posedge clk) disable iff (rst)
      (enable && !rotate_mode) |=> ($countones(state ^ $past(state)) == 1));

   // R3: rotation keeps the number of ones
   a_r3_rotate_ones: assert property (@(posedge clk) disable iff (rst)
      (enable && rotate_mode && keep_fill) |=> ($countones(state) == $countones($past(state))));

   // R5: zero fill puts a zero into the head stage
   a_r5_zero_head: assert property (@(posedge clk) disable iff (rst)
      (enable && rotate_mode && !keep_fill) |=> !state[0]);

   // R1: counting head stage takes the inverse of the previous tail
   a_r1_invert_feedback: assert property (@(posedge clk) disable iff (rst)
      (enable && !rotate_mode) |=> (state[0] == !$past(state[LAST])));

endmodule

// File: tb/johnson_reconfig_bench.sv
module johnson_reconfig_bench;

   localparam int L      = 8;
   localparam int PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst, enable, rotate_mode, keep_fill;
   logic [L-1:0] state;
   logic         serial_out;

   int total = 0;
   int bad   = 0;

   johnson_reconfig #(.STAGES(L)) u_johnson_reconfig (
      .clk(clk), .rst(rst), .enable(enable), .rotate_mode(rotate_mode),
      .keep_fill(keep_fill), .state(state), .serial_out(serial_out)
   );

   always #(PERIOD/2) clk = ~clk;

   function automatic logic [L-1:0] count_value(input int k);
      logic [L:0] ones;
      if (k <= L) begin
         ones = (L+1)'(1) << k;
         return L'(ones - 1);
      end
      ones = (L+1)'(1) << (k - L);
      return ~L'(ones - 1);
   endfunction

   function automatic logic [L-1:0] rot_value(input logic [L-1:0] v);
      return {v[L-2:0], v[L-1]};
   endfunction

   task automatic check(input logic [L-1:0] act, input logic [L-1:0] exp, input string req);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
      total++;
      if (serial_out !== act[L-1]) begin
         bad++;
         $display("FAIL R8 actual=%b expected=%b", serial_out, act[L-1]);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst = 1'b1; tick(); rst = 1'b0;
   endtask

   initial begin
      logic [L-1:0] start, exp;
      rst = 1'b1; enable = 1'b0; rotate_mode = 1'b0; keep_fill = 1'b0;
      tick(); tick();
      check(state, '0, "R7 reset");
      rst = 1'b0;

      // R1 and R2: full counting period from zero
      enable = 1'b1; rotate_mode = 1'b0;
      for (int k = 1; k <= 2*L; k++) begin
         start = state;
         tick();
         check(state, count_value(k % (2*L)), "R1 count");
         total++;
         if ($countones(state ^ start) != 1) begin
            bad++;
            $display("FAIL R2 actual=%0d expected=1", $countones(state ^ start));
         end
      end

      // R3 and R4: rotate every counting state through a full turn
      for (int s = 0; s < 2*L; s++) begin
         do_reset();
         enable = 1'b1; rotate_mode = 1'b0;
         for (int k = 0; k < s; k++) tick();
         start = state;
         rotate_mode = 1'b1; keep_fill = 1'b1;
         exp = start;
         for (int r = 0; r < L; r++) begin
            tick();
            exp = rot_value(exp);
            check(state, exp, "R3 rotate");
         end
         check(state, start, "R4 full turn");
      end

      // R5: zero fill from all ones
      do_reset();
      enable = 1'b1; rotate_mode = 1'b0;
      for (int k = 0; k < L; k++) tick();
      check(state, '1, "R1 all ones");
      rotate_mode = 1'b1; keep_fill = 1'b0;
      exp = '1;
      for (int k = 0; k < L; k++) begin
         tick();
         exp = exp << 1;
         check(state, exp, "R5 zero fill");
      end
      check(state, '0, "R5 cleared");

      // R6: hold with enable low in each mode
      do_reset();
      enable = 1'b1; rotate_mode = 1'b0;
      for (int k = 0; k < 3; k++) tick();
      start = state;
      enable = 1'b0;
      for (int m = 0; m < 3; m++) begin
         rotate_mode = (m != 0);
         keep_fill   = (m == 1);
         tick(); tick();
         check(state, start, "R6 hold");
      end

      // R7: reset wins over enable and counting
      enable = 1'b1; rotate_mode = 1'b0; rst = 1'b1;
      tick();
      check(state, '0, "R7 reset priority");
      rst = 1'b0;
      tick();
      check(state, count_value(1), "R1 after reset");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(PERIOD * 200000);
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule